// File: doc/BRIEF.md
# Self-Sync Gap and Data Field Writer

This block produces the serial bit stream for the write half of a sector update. After a start request it drives one bit per bit cell on a write-data output. The stream begins with a lead-in gap of self-sync nibbles, then carries the three-nibble data prologue, then the caller's data nibbles, and ends with a three-nibble epilog. The write-enable output is high for the whole field.

Each self-sync nibble is eight one bits followed by zero bits. Because the zero bits make these nibbles longer than an ordinary nibble, a reader that begins at an arbitrary bit position drifts into correct byte framing before the prologue arrives. A format input selects whether each self-sync nibble has one trailing zero or two.

Data nibbles arrive through a ready/valid handshake. The block holds one nibble in a buffer ahead of the nibble being shifted out, so the stream never waits for data in the middle of the field. Each bit cell lasts a fixed number of sequencer clocks.

Top module: `gapfield_writer`

## Requirements
- R1: After reset, `wr_en`, `done`, `din_ready` and `wr_bit` are all 0.
- R2: The field opens with `gap_count` self-sync nibbles. Each one is eight 1 cells followed by one 0 cell when `fmt_long`=0 (nine cells), or by two 0 cells when `fmt_long`=1 (ten cells).
- R3: After the gap come the nibbles D5, AA, AD, then the data nibbles in acceptance order, then DE, AA, EB. Each of these nibbles is eight cells, MSB first, with no trailing zeros.
- R4: Every bit cell lasts `CELL_CLKS` clocks. `wr_bit` is constant within a cell. The first cell begins at the rising edge that accepts `start`, and `wr_en` stays 1 through every cell of the field.
- R5: `done` is 1 for exactly one clock. It rises at the same edge where `wr_en` falls, which is the edge that ends the last epilog cell.
- R6: Exactly `data_count` nibbles are taken, one at each rising edge where `din_valid` and `din_ready` are both 1. `din_ready` is 0 whenever `wr_en` is 0.
- R7: A `start` is ignored when `gap_count` is below the guaranteed-sync minimum for the format (7 when `fmt_long`=0, 4 when `fmt_long`=1) or when `data_count` is 0. In that case `wr_en`, `din_ready` and `done` stay 0.
- R8: A `start` that arrives while a field is being written is ignored, and the stream in progress is unchanged.
- R9: With the gap at its minimum, a reader that starts at any cell of the first self-sync nibble receives D5 AA AD correctly framed. The reader shifts cells in and takes a byte once its MSB is 1.
- R10: `wr_bit` is 0 whenever `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a field |
| fmt_long | input | 1 | 1 selects ten-cell self-sync nibbles, 0 selects nine-cell nibbles |
| gap_count | input | GAP_W | Number of self-sync nibbles in the lead-in gap |
| data_count | input | CNT_W | Number of data nibbles in the field |
| din | input | 8 | Data nibble offered |
| din_valid | input | 1 | `din` holds a nibble |
| din_ready | output | 1 | Block will take `din` at the next edge |
| wr_bit | output | 1 | Serial write data, one value per bit cell |
| wr_en | output | 1 | High while the field is being written |
| done | output | 1 | One-clock pulse at the end of the field |

## Verification
The assertions assume the data source always answers a request in time. The buffered nibble must already be present when the serializer reaches a data nibble, which leaves the source nearly a full nibble time to respond. The stimulus keeps `din_valid` high and updates `din` within two clocks of each accepted transfer. Configuration inputs change only while the block is idle, apart from the deliberate mid-field `start`. That `start` repeats the configuration already in use, so R8 can be observed through the serial stream.

// File: rtl/gfw_pkg.sv
package gfw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_PRO,
        PH_DATA,
        PH_EPI
    } phase_t;

    localparam int SH_W  = 10;
    localparam int LEN_W = 4;

    typedef struct packed {
        logic [SH_W-1:0]  word;
        logic [LEN_W-1:0] len;
    } nib_t;

    function automatic nib_t sync_nib(input logic fmt_long);
        nib_t n;
        n.word = 10'b11_1111_1100;
        n.len  = fmt_long ? 4'd10 : 4'd9;
        return n;
    endfunction

    function automatic nib_t byte_nib(input logic [7:0] b);
        nib_t n;
        n.word = {b, 2'b00};
        n.len  = 4'd8;
        return n;
    endfunction

    function automatic logic [7:0] pro_byte(input logic [1:0] i);
        case (i)
            2'd0:    return 8'hD5;
            2'd1:    return 8'hAA;
            default: return 8'hAD;
        endcase
    endfunction

    function automatic logic [7:0] epi_byte(input logic [1:0] i);
        case (i)
            2'd0:    return 8'hDE;
            2'd1:    return 8'hAA;
            default: return 8'hEB;
        endcase
    endfunction

    function automatic logic [3:0] min_gap(input logic fmt_long);
        return fmt_long ? 4'd4 : 4'd7;
    endfunction

endpackage

// File: rtl/gfw_cell_timer.sv
module gfw_cell_timer #(
    parameter int CELL_CLKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic cell_end
);
    localparam int TW = (CELL_CLKS > 2) ? $clog2(CELL_CLKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(CELL_CLKS - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cell_end = run && (cnt == LAST);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);  // R4

endmodule

// File: rtl/gfw_shifter.sv
module gfw_shifter
    import gfw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  nib_t load_nib,
    input  logic adv,
    output logic ser_bit,
    output logic last_cell
);
    logic [SH_W-1:0]  sh;
    logic [LEN_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= load_nib.word;
            left <= load_nib.len;
        end else if (adv) begin
            sh   <= {sh[SH_W-2:0], 1'b0};
            left <= (left != '0) ? left - 1'b1 : '0;
        end
    end

    assign ser_bit   = sh[SH_W-1];
    assign last_cell = (left == LEN_W'(1));

    AST_HOLD_MIDCELL: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(ser_bit));  // R4

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_nib.len >= 4'd8 && load_nib.len <= 4'd10));  // R2

endmodule

// File: rtl/gapfield_writer.sv
module gapfield_writer
    import gfw_pkg::*;
#(
    parameter int CELL_CLKS = 8,
    parameter int GAP_W     = 6,
    parameter int CNT_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fmt_long,
    input  logic [GAP_W-1:0] gap_count,
    input  logic [CNT_W-1:0] data_count,
    input  logic [7:0]       din,
    input  logic             din_valid,
    output logic             din_ready,
    output logic             wr_bit,
    output logic             wr_en,
    output logic             done
);
    localparam int RW = (GAP_W > CNT_W) ? GAP_W : CNT_W;

    phase_t           phase, nxt_phase;
    logic [RW-1:0]    rem, nxt_rem;
    logic [1:0]       idx, nxt_idx;
    logic             fmt_q;
    logic [CNT_W-1:0] dcnt_q, fetched;
    logic [7:0]       buf_q;
    logic             buf_full;
    logic             done_q;

    logic busy, start_ok, cell_end, last_cell, ser_bit;
    logic ld, consume, finish, accept;
    nib_t ld_nib;

    assign busy     = (phase != PH_IDLE);
    assign start_ok = start && !busy && (data_count != '0)
                      && (gap_count >= GAP_W'(min_gap(fmt_long)));

    gfw_cell_timer #(.CELL_CLKS(CELL_CLKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .cell_end (cell_end)
    );

    gfw_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (ld),
        .load_nib  (ld_nib),
        .adv       (cell_end),
        .ser_bit   (ser_bit),
        .last_cell (last_cell)
    );

    always_comb begin
        nxt_phase = phase;
        nxt_rem   = rem;
        nxt_idx   = idx;
        ld        = 1'b0;
        ld_nib    = '0;
        consume   = 1'b0;
        finish    = 1'b0;
        if (start_ok) begin
            nxt_phase = PH_SYNC;
            nxt_rem   = RW'(gap_count);
            nxt_idx   = '0;
            ld        = 1'b1;
            ld_nib    = sync_nib(fmt_long);
        end else if (busy && cell_end && last_cell) begin
            case (phase)
                PH_SYNC: begin
                    ld = 1'b1;
                    if (rem > RW'(1)) begin
                        nxt_rem = rem - 1'b1;
                        ld_nib  = sync_nib(fmt_q);
                    end else begin
                        nxt_phase = PH_PRO;
                        nxt_idx   = '0;
                        ld_nib    = byte_nib(pro_byte(2'd0));
                    end
                end
                PH_PRO: begin
                    ld = 1'b1;
                    if (idx != 2'd2) begin
                        nxt_idx = idx + 1'b1;
                        ld_nib  = byte_nib(pro_byte(2'(idx + 1'b1)));
                    end else begin
                        nxt_phase = PH_DATA;
                        nxt_rem   = RW'(dcnt_q);
                        ld_nib    = byte_nib(buf_q);
                        consume   = 1'b1;
                    end
                end
                PH_DATA: begin
                    ld = 1'b1;
                    if (rem > RW'(1)) begin
                        nxt_rem = rem - 1'b1;
                        ld_nib  = byte_nib(buf_q);
                        consume = 1'b1;
                    end else begin
                        nxt_phase = PH_EPI;
                        nxt_idx   = '0;
                        ld_nib    = byte_nib(epi_byte(2'd0));
                    end
                end
                PH_EPI: begin
                    if (idx != 2'd2) begin
                        ld      = 1'b1;
                        nxt_idx = idx + 1'b1;
                        ld_nib  = byte_nib(epi_byte(2'(idx + 1'b1)));
                    end else begin
                        nxt_phase = PH_IDLE;
                        finish    = 1'b1;
                    end
                end
                default: nxt_phase = PH_IDLE;
            endcase
        end
    end

    assign din_ready = busy && !buf_full && (fetched != dcnt_q);
    assign accept    = din_valid && din_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            rem      <= '0;
            idx      <= '0;
            fmt_q    <= 1'b0;
            dcnt_q   <= '0;
            fetched  <= '0;
            buf_q    <= '0;
            buf_full <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            phase  <= nxt_phase;
            rem    <= nxt_rem;
            idx    <= nxt_idx;
            done_q <= finish;
            if (start_ok) begin
                fmt_q    <= fmt_long;
                dcnt_q   <= data_count;
                fetched  <= '0;
                buf_full <= 1'b0;
            end else if (accept) begin
                buf_q    <= din;
                buf_full <= 1'b1;
                fetched  <= fetched + 1'b1;
            end else if (consume) begin
                buf_full <= 1'b0;
            end
        end
    end

    assign wr_en  = busy;
    assign wr_bit = busy && ser_bit;
    assign done   = done_q;

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_en) |-> done);  // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R5

    AST_FEED_AHEAD: assert property (@(posedge clk) disable iff (rst)
        consume |-> buf_full);  // R6

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !din_ready);  // R6

    AST_FETCH_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (fetched <= dcnt_q));  // R6

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_bit);  // R10

endmodule

// File: tb/sim_gapfield_writer.sv
`timescale 1ns/1ps
module sim_gapfield_writer;
    localparam int C  = 8;
    localparam int GW = 6;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          fmt_long = 1'b0;
    logic [GW-1:0] gap_count = '0;
    logic [CW-1:0] data_count = '0;
    logic [7:0]    din;
    logic          din_valid = 1'b0;
    logic          din_ready, wr_bit, wr_en, done;

    gapfield_writer #(.CELL_CLKS(C), .GAP_W(GW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .fmt_long(fmt_long),
        .gap_count(gap_count), .data_count(data_count),
        .din(din), .din_valid(din_valid), .din_ready(din_ready),
        .wr_bit(wr_bit), .wr_en(wr_en), .done(done)
    );

    always #2.5 clk = ~clk;

    int   checks = 0;
    int   errors = 0;
    int   k = 0;
    logic prev_take = 1'b0;
    logic exp_b [0:1023];
    logic got_b [0:1023];
    int   nexp;
    int   gap_cells;
    bit   finished = 1'b0;

    function automatic logic [7:0] fdat(input int m);
        return 8'(m * 29 + 147) | 8'h80;
    endfunction

    initial din = fdat(0);

    always @(negedge clk) begin
        if (prev_take) k = k + 1;
        din = fdat(k);
        prev_take = din_ready && din_valid;
    end

    task automatic chk(input string tag, input int got, input int expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, got, expv);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            exp_b[nexp] = b[i];
            nexp++;
        end
    endtask

    task automatic reader(input int o, output bit ok);
        logic [7:0]  sr;
        logic [23:0] last;
        sr = '0; last = '0; ok = 1'b0;
        for (int i = o; i < nexp; i++) begin
            sr = {sr[6:0], got_b[i]};
            if (sr[7]) begin
                last = {last[15:0], sr};
                if (last == 24'hD5AAAD) ok = 1'b1;
                sr = '0;
            end
        end
    endtask

    task automatic run(input logic fl, input int g, input int d);
        int base, slen, bad_gap, bad_rest, wen_bad, hold_bad;
        bit ok;
        slen = fl ? 10 : 9;
        nexp = 0;
        for (int gi = 0; gi < g; gi++)
            for (int b = 0; b < slen; b++) begin
                exp_b[nexp] = (b < 8);
                nexp++;
            end
        gap_cells = nexp;
        base = k;
        push_byte(8'hD5); push_byte(8'hAA); push_byte(8'hAD);
        for (int m = 0; m < d; m++) push_byte(fdat(base + m));
        push_byte(8'hDE); push_byte(8'hAA); push_byte(8'hEB);

        @(negedge clk);
        fmt_long = fl; gap_count = GW'(g); data_count = CW'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wen_bad = 0; hold_bad = 0;
        for (int i = 0; i < nexp; i++) begin
            got_b[i] = wr_bit;
            if (wr_en !== 1'b1) wen_bad++;
            if (i == 3) start = 1'b1;   // R8: restart attempt mid-field
            for (int j = 0; j < C; j++) begin
                @(negedge clk);
                start = 1'b0;
                if (j == C - 2 && wr_bit !== got_b[i]) hold_bad++;
            end
        end
        chk("R5 done at end", done, 1);
        chk("R5 wr_en low at end", wr_en, 0);
        bad_gap = 0; bad_rest = 0;
        for (int i = 0; i < nexp; i++)
            if (got_b[i] !== exp_b[i]) begin
                if (i < gap_cells) bad_gap++; else bad_rest++;
            end
        chk("R2 sync gap cells wrong", bad_gap, 0);
        chk("R3 R8 field cells wrong", bad_rest, 0);
        chk("R4 wr_en drop inside field", wen_bad, 0);
        chk("R4 wr_bit changed inside cell", hold_bad, 0);
        @(negedge clk);
        chk("R5 done single pulse", done, 0);
        chk("R10 wr_bit idle", wr_bit, 0);
        chk("R6 nibbles accepted", k - base, d);
        if (g == (fl ? 4 : 7))
            for (int o = 0; o < slen; o++) begin
                reader(o, ok);
                chk("R9 reader framing", ok, 1);
            end
    endtask

    task automatic reject(input logic fl, input int g, input int d);
        int bad;
        @(negedge clk);
        fmt_long = fl; gap_count = GW'(g); data_count = CW'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (wr_en || din_ready || done) bad++;
            @(negedge clk);
        end
        chk("R7 start ignored", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual expired expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 wr_en reset", wr_en, 0);
        chk("R1 done reset", done, 0);
        chk("R1 din_ready reset", din_ready, 0);
        chk("R1 wr_bit reset", wr_bit, 0);
        din_valid = 1'b1;
        for (int fl = 0; fl < 2; fl++)
            for (int gx = 0; gx < 2; gx++)
                for (int dx = 0; dx < 2; dx++)
                    run(fl[0], (fl != 0 ? 4 : 7) + gx * 3, dx != 0 ? 4 : 1);
        reject(1'b0, 6, 2);
        reject(1'b1, 3, 2);
        reject(1'b1, 8, 0);
        run(1'b1, 6, 2);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule